// File: doc/BRIEF.md
# Two-Bank IN Endpoint Transmit Buffer

This block is the device-side transmit store for one bulk or interrupt IN endpoint of a full-speed USB device. It keeps two packet banks that take turns, so software can load the next payload while the previous one is still waiting to go out. Software pushes bytes through a single write stream. It also drives plain control pulses that arm a bank (the packet-ready flag) and clear the transmit-complete flag. The interrupt line mirrors the transmit-complete flag.

On the token side, a simplified front end signals each IN token and the host's reply. If a bank is armed, the block streams that bank's bytes on a valid/ready output. If no bank is armed, it raises a one-cycle NAK pulse. When the host acknowledges the packet, the bank is released to software: packet-ready drops and transmit-complete rises. When the host times out, the same bank stays armed and is sent again on the next token.

Both streams follow valid/ready rules. A write byte is taken on a cycle where `wr_valid` and `wr_ready` are both high. A transmit beat leaves on a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the offered beat is held unchanged. Software is expected to arm the second, already-filled bank only after it sees transmit-complete, and to clear transmit-complete after that re-arm.

Top module: `inep_pingpong_tx`

## Requirements
- R1: After reset, `pkt_rdy`, `tx_done`, `irq`, `tx_valid` and `tok_nak` are 0 and `wr_ready` is 1. The first payload written lands in bank 0, and bank 0 is the first bank transmitted.
- R2: A byte is stored when `wr_valid` and `wr_ready` are both high. A bank holds up to MAX_PKT bytes. `wr_ready` is low once the bank being filled holds MAX_PKT bytes, and bytes offered then are dropped.
- R3: `sw_set_rdy` while `pkt_rdy` is 0 sets `pkt_rdy` on the next cycle. It latches the fill count for that bank, including a byte accepted in the same cycle. Later writes then go to the other bank, starting empty.
- R4: `sw_set_rdy` while `pkt_rdy` is 1 is ignored. `pkt_rdy` stays 1, and the bank being filled keeps its bytes and keeps accepting more.
- R5: A `tok_in` pulse while no bank is armed and the transmitter is idle produces a one-cycle `tok_nak` pulse on the next cycle, and no transmit beat.
- R6: A `tok_in` pulse while a bank is armed makes the next cycle start streaming exactly the latched count of that bank's bytes, in write order. `tx_last` is 1 on the final beat. A count of zero gives one beat with `tx_empty`=1 and `tx_last`=1. A beat stays stable while `tx_ready` is low.
- R7: `hs_ack` after the last beat clears `pkt_rdy` and sets `tx_done` on the next cycle. The following transmission then comes from the other bank.
- R8: `hs_timeout` after the last beat leaves `pkt_rdy` at 1 and `tx_done` unchanged. The next IN token resends the same bytes.
- R9: `irq` equals `tx_done`. `sw_clr_done` clears `tx_done` on the next cycle unless an acknowledge sets it in the same cycle.
- R10: `hs_ack` or `hs_timeout` arriving while no packet awaits a handshake has no effect on `pkt_rdy` or `tx_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Software byte offered |
| wr_ready | output | 1 | Fill bank has room |
| wr_data | input | DATA_W | Payload byte |
| sw_set_rdy | input | 1 | Pulse: arm the bank just filled |
| sw_clr_done | input | 1 | Pulse: clear transmit-complete |
| pkt_rdy | output | 1 | Packet-ready flag |
| tx_done | output | 1 | Transmit-complete flag |
| irq | output | 1 | Interrupt, high while tx_done is set |
| tok_in | input | 1 | Pulse: IN token received |
| hs_ack | input | 1 | Pulse: host acknowledged |
| hs_timeout | input | 1 | Pulse: host did not acknowledge |
| tok_nak | output | 1 | Pulse: answer NAK |
| tx_valid | output | 1 | Transmit beat offered |
| tx_ready | input | 1 | Sink accepts beat |
| tx_data | output | DATA_W | Transmit byte |
| tx_last | output | 1 | Final beat of the packet |
| tx_empty | output | 1 | Zero-length packet beat, data invalid |

## Verification
The checker watches several rules on every cycle:
- NAK pulses follow only an unarmed token.
- A transmit beat appears only while a bank is armed.
- Stalled beats hold their value.
- A zero-length beat is always the last beat.
- `pkt_rdy` rises only after a set request.
- `tx_done` rises only together with a falling `pkt_rdy` and falls only after a clear request.

Other behaviours need whole scenarios and can only be shown by the bench:
- byte order and exact packet length;
- the alternation of banks;
- a resend after a timeout;
- a rejected re-arm leaving the fill bank intact;
- a write merged into the same cycle as an arm.

// File: rtl/inep_pkg.sv
package inep_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_SEND = 2'd1,
    TX_WAIT = 2'd2
  } tx_state_e;

  localparam int NUM_BANKS = 2;
endpackage

// File: rtl/inep_bank_store.sv
module inep_bank_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              wbank,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rbank,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] bank_rd [inep_pkg::NUM_BANKS];

  for (genvar b = 0; b < inep_pkg::NUM_BANKS; b++) begin : g_bank
    logic [DATA_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we && (wbank == 1'(b))) mem[waddr] <= wdata;
    end
    assign bank_rd[b] = mem[raddr];
  end

  assign rdata = bank_rd[rbank];
endmodule

// File: rtl/inep_fill_ctrl.sv
module inep_fill_ctrl #(
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_valid,
  output logic                  wr_ready,
  input  logic                  arm_ok,
  output logic                  we,
  output logic                  wbank,
  output logic [IDX_W-1:0]      waddr,
  output logic [1:0][CNT_W-1:0] bank_len
);
  logic [CNT_W-1:0] fill_cnt;
  logic             fill_bank;

  assign wr_ready = (fill_cnt < CNT_W'(DEPTH));
  assign we       = wr_valid && wr_ready;
  assign wbank    = fill_bank;
  assign waddr    = fill_cnt[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_cnt  <= '0;
      fill_bank <= 1'b0;
      bank_len  <= '0;
    end else if (arm_ok) begin
      bank_len[fill_bank] <= fill_cnt + CNT_W'(we);
      fill_cnt            <= '0;
      fill_bank           <= ~fill_bank;
    end else if (we) begin
      fill_cnt <= fill_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/inep_flag_ctrl.sv
module inep_flag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic clr_req,
  input  logic ack_done,
  output logic arm_ok,
  output logic pkt_rdy,
  output logic tx_done
);
  assign arm_ok = set_req && !pkt_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_rdy <= 1'b0;
      tx_done <= 1'b0;
    end else begin
      if (arm_ok)        pkt_rdy <= 1'b1;
      else if (ack_done) pkt_rdy <= 1'b0;
      if (ack_done)      tx_done <= 1'b1;
      else if (clr_req)  tx_done <= 1'b0;
    end
  end
endmodule

// File: rtl/inep_tx_engine.sv
module inep_tx_engine #(
  parameter int DEPTH  = 64,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tok_in,
  input  logic             hs_ack,
  input  logic             hs_timeout,
  input  logic             pkt_rdy,
  input  logic [CNT_W-1:0] cur_len,
  input  logic             tx_ready,
  output logic             tx_valid,
  output logic             tx_last,
  output logic             tx_empty,
  output logic             tx_bank,
  output logic [IDX_W-1:0] raddr,
  output logic             tok_nak,
  output logic             ack_done
);
  import inep_pkg::*;

  tx_state_e        state;
  logic [IDX_W-1:0] rd_idx;

  assign tx_valid = (state == TX_SEND);
  assign tx_empty = tx_valid && (cur_len == '0);
  assign tx_last  = tx_valid && ((cur_len == '0) ||
                                 (CNT_W'(rd_idx) == cur_len - CNT_W'(1)));
  assign raddr    = rd_idx;
  assign ack_done = (state == TX_WAIT) && hs_ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= TX_IDLE;
      rd_idx  <= '0;
      tx_bank <= 1'b0;
      tok_nak <= 1'b0;
    end else begin
      tok_nak <= (state == TX_IDLE) && tok_in && !pkt_rdy;
      unique case (state)
        TX_IDLE: begin
          if (tok_in && pkt_rdy) begin
            state  <= TX_SEND;
            rd_idx <= '0;
          end
        end
        TX_SEND: begin
          if (tx_ready) begin
            if (tx_last) state <= TX_WAIT;
            else         rd_idx <= rd_idx + IDX_W'(1);
          end
        end
        TX_WAIT: begin
          if (hs_ack) begin
            state   <= TX_IDLE;
            tx_bank <= ~tx_bank;
          end else if (hs_timeout) begin
            state <= TX_IDLE;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/inep_pingpong_tx.sv
module inep_pingpong_tx #(
  parameter int DATA_W  = 8,
  parameter int MAX_PKT = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              sw_set_rdy,
  input  logic              sw_clr_done,
  output logic              pkt_rdy,
  output logic              tx_done,
  output logic              irq,
  input  logic              tok_in,
  input  logic              hs_ack,
  input  logic              hs_timeout,
  output logic              tok_nak,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  output logic              tx_last,
  output logic              tx_empty
);
  localparam int IDX_W = $clog2(MAX_PKT);
  localparam int CNT_W = $clog2(MAX_PKT + 1);

  logic                  we, wbank, arm_ok, ack_done, tx_bank;
  logic [IDX_W-1:0]      waddr, raddr;
  logic [1:0][CNT_W-1:0] bank_len;
  logic [CNT_W-1:0]      cur_len;

  assign cur_len = bank_len[tx_bank];
  assign irq     = tx_done;

  inep_fill_ctrl #(.DEPTH(MAX_PKT)) u_fill (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .arm_ok(arm_ok), .we(we), .wbank(wbank), .waddr(waddr), .bank_len(bank_len)
  );

  inep_flag_ctrl u_flags (
    .clk(clk), .rst_n(rst_n), .set_req(sw_set_rdy), .clr_req(sw_clr_done),
    .ack_done(ack_done), .arm_ok(arm_ok), .pkt_rdy(pkt_rdy), .tx_done(tx_done)
  );

  inep_bank_store #(.DATA_W(DATA_W), .DEPTH(MAX_PKT)) u_store (
    .clk(clk), .we(we), .wbank(wbank), .waddr(waddr), .wdata(wr_data),
    .rbank(tx_bank), .raddr(raddr), .rdata(tx_data)
  );

  inep_tx_engine #(.DEPTH(MAX_PKT)) u_tx (
    .clk(clk), .rst_n(rst_n), .tok_in(tok_in), .hs_ack(hs_ack),
    .hs_timeout(hs_timeout), .pkt_rdy(pkt_rdy), .cur_len(cur_len),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_last(tx_last),
    .tx_empty(tx_empty), .tx_bank(tx_bank), .raddr(raddr),
    .tok_nak(tok_nak), .ack_done(ack_done)
  );
endmodule

// File: rtl/inep_pingpong_tx_chk.sv
module inep_pingpong_tx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sw_set_rdy,
  input logic              sw_clr_done,
  input logic              pkt_rdy,
  input logic              tx_done,
  input logic              tok_in,
  input logic              tok_nak,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_last,
  input logic              tx_empty
);
  AST_NAK_ONLY_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    tok_nak |-> ($past(tok_in) && !$past(pkt_rdy))); // R5

  AST_NO_BEAT_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> pkt_rdy); // R5

  AST_STALL_HOLDS_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)
                                 && $stable(tx_empty))); // R6

  AST_EMPTY_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    tx_empty |-> (tx_valid && tx_last)); // R6

  AST_ARM_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pkt_rdy) |-> $past(sw_set_rdy)); // R3

  AST_DONE_WITH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_done) |-> $fell(pkt_rdy)); // R7

  AST_DONE_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_done) |-> $past(sw_clr_done)); // R9
endmodule

bind inep_pingpong_tx inep_pingpong_tx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw_set_rdy(sw_set_rdy), .sw_clr_done(sw_clr_done),
  .pkt_rdy(pkt_rdy), .tx_done(tx_done), .tok_in(tok_in), .tok_nak(tok_nak),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
  .tx_last(tx_last), .tx_empty(tx_empty)
);

// File: tb/tb_inep_pingpong_tx.sv
module tb_inep_pingpong_tx;
  localparam int DW = 8;
  localparam int MAXP = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0, sw_set_rdy = 1'b0, sw_clr_done = 1'b0;
  logic tok_in = 1'b0, hs_ack = 1'b0, hs_timeout = 1'b0, tx_ready = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, pkt_rdy, tx_done, irq, tok_nak, tx_valid, tx_last, tx_empty;
  logic [DW-1:0] tx_data;

  int total = 0;
  int bad = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  inep_pingpong_tx #(.DATA_W(DW), .MAX_PKT(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .sw_set_rdy(sw_set_rdy), .sw_clr_done(sw_clr_done),
    .pkt_rdy(pkt_rdy), .tx_done(tx_done), .irq(irq), .tok_in(tok_in),
    .hs_ack(hs_ack), .hs_timeout(hs_timeout), .tok_nak(tok_nak),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_empty(tx_empty)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic int pick_len();
    return (($urandom % 8) == 0) ? MAXP : int'($urandom % (MAXP + 1));
  endfunction

  task automatic push(input int n, ref logic [DW-1:0] q[$]);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_valid = 1'b1;
      wr_data  = DW'($urandom);
      q.push_back(wr_data);
    end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic pulse_set();
    @(negedge clk); sw_set_rdy = 1'b1;
    @(negedge clk); sw_set_rdy = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); sw_clr_done = 1'b1;
    @(negedge clk); sw_clr_done = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); hs_ack = 1'b1;
    @(negedge clk); hs_ack = 1'b0;
  endtask

  task automatic pulse_timeout();
    @(negedge clk); hs_timeout = 1'b1;
    @(negedge clk); hs_timeout = 1'b0;
  endtask

  // Issue a token and collect the packet; compare against the model queue.
  task automatic receive(input string req, ref logic [DW-1:0] q[$]);
    int got = 0;
    bit fin = 0;
    @(negedge clk); tok_in = 1'b1;
    @(negedge clk); tok_in = 1'b0;
    chk({req, " tok_nak"}, int'(tok_nak), 0);
    for (int guard = 0; guard < 4000 && !fin; guard++) begin
      if (tx_valid) begin
        tx_ready = (($urandom % 4) != 0);
        if (tx_ready) begin
          if (q.size() == 0) begin
            chk({req, " zero-length beat"}, int'(tx_empty && tx_last), 1);
          end else begin
            chk({req, " data"}, int'(tx_data), int'(q[got]));
            chk({req, " last"}, int'(tx_last), int'(got == q.size() - 1));
            got++;
          end
          if (tx_last) fin = 1;
        end
      end else begin
        tx_ready = 1'b0;
      end
      @(negedge clk);
    end
    tx_ready = 1'b0;
    chk({req, " length"}, q.size() == 0 ? int'(fin) : got,
        q.size() == 0 ? 1 : q.size());
  endtask

  initial begin
    for (int c = 0; c < 100000; c++) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [DW-1:0] qa[$];
    logic [DW-1:0] qb[$];
    logic [DW-1:0] extra;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 pkt_rdy", int'(pkt_rdy), 0);
    chk("R1 tx_done", int'(tx_done), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 tx_valid", int'(tx_valid), 0);
    chk("R1 tok_nak", int'(tok_nak), 0);
    chk("R1 wr_ready", int'(wr_ready), 1);

    // R5 token with nothing armed
    @(negedge clk); tok_in = 1'b1;
    @(negedge clk); tok_in = 1'b0;
    chk("R5 nak pulse", int'(tok_nak), 1);
    chk("R5 no beat", int'(tx_valid), 0);
    @(negedge clk);
    chk("R5 nak one cycle", int'(tok_nak), 0);

    // R3 arm bank 0; fill bank 1 while bank 0 pending
    qa = {}; qb = {};
    push(5, qa);
    pulse_set();
    chk("R3 pkt_rdy set", int'(pkt_rdy), 1);
    chk("R3 wr_ready other bank", int'(wr_ready), 1);
    push(3, qb);
    // R4 re-arm while armed is ignored; bank 1 keeps collecting
    pulse_set();
    chk("R4 pkt_rdy stays", int'(pkt_rdy), 1);
    push(1, qb);
    // R10 stray handshakes with nothing awaiting
    pulse_ack();
    chk("R10 ack ignored pkt_rdy", int'(pkt_rdy), 1);
    chk("R10 ack ignored tx_done", int'(tx_done), 0);
    pulse_timeout();
    chk("R10 timeout ignored", int'(pkt_rdy), 1);

    // R1 / R6 bank 0 first
    receive("R6 bank0", qa);
    // R8 timeout keeps bank armed and resends
    pulse_timeout();
    chk("R8 pkt_rdy kept", int'(pkt_rdy), 1);
    chk("R8 tx_done unchanged", int'(tx_done), 0);
    receive("R8 resend", qa);
    // R7 ack releases bank
    pulse_ack();
    chk("R7 pkt_rdy cleared", int'(pkt_rdy), 0);
    chk("R7 tx_done set", int'(tx_done), 1);
    chk("R9 irq follows", int'(irq), 1);
    pulse_set();
    pulse_clr();
    chk("R9 tx_done cleared", int'(tx_done), 0);
    chk("R9 irq cleared", int'(irq), 0);
    // R4 / R7 bank 1 with all four bytes
    receive("R7 bank1 R4 kept", qb);
    pulse_ack();
    pulse_clr();

    // R6 zero-length packet
    qa = {};
    pulse_set();
    receive("R6 zero-length", qa);
    pulse_ack();
    pulse_clr();

    // R2 full bank back-pressure
    qa = {};
    push(MAXP, qa);
    chk("R2 wr_ready low when full", int'(wr_ready), 0);
    @(negedge clk); wr_valid = 1'b1; wr_data = 8'hEE;
    @(negedge clk); wr_valid = 1'b0;
    pulse_set();
    receive("R2 full bank", qa);
    pulse_ack();
    pulse_clr();

    // R3 byte written in the arming cycle is included
    qa = {};
    push(2, qa);
    @(negedge clk);
    extra = DW'($urandom);
    wr_valid = 1'b1; wr_data = extra; sw_set_rdy = 1'b1;
    qa.push_back(extra);
    @(negedge clk); wr_valid = 1'b0; sw_set_rdy = 1'b0;
    receive("R3 merged byte", qa);
    pulse_ack();
    pulse_clr();

    // Random packets
    for (int it = 0; it < 30; it++) begin
      qa = {};
      push(pick_len(), qa);
      pulse_set();
      chk("R3 random arm", int'(pkt_rdy), 1);
      receive("R6 random", qa);
      if (($urandom % 3) == 0) begin
        pulse_timeout();
        chk("R8 random kept", int'(pkt_rdy), 1);
        receive("R8 random resend", qa);
      end
      pulse_ack();
      chk("R7 random release", int'(pkt_rdy), 0);
      chk("R9 random irq", int'(irq), 1);
      pulse_clr();
      chk("R9 random clear", int'(tx_done), 0);
    end

    finish_run();
  end
endmodule